// File: doc/BRIEF.md
# Paired 40-bit Event Counter

The block holds two 40-bit event counters for performance monitoring. Each counter has its own enable and an event-select field that picks one of several pulse lines. A counter advances by one in every clock cycle in which its selected line is high, but only while its own enable and a shared master enable are both set. Clearing the master enable stops both counters on the same edge.

When a counter wraps from all ones to zero, it raises a one-cycle overflow pulse. Each counter has its own 40-bit reload register. A per-counter reload mode decides whether the reload value replaces the count:
- when the counter itself wraps,
- when its partner wraps,
- in either case,
- or never.

Software uses a simple register port to read and write the counts, the reload values, the per-counter controls and the master enable. A 40-bit quantity is split into a low 32-bit word and a high 8-bit word. Software should stop the counters before it accesses a count, because an access made while they run is not coherent.

Top module: `evtCounterPair`

## Requirements
- R1: After reset, both counts, both reload values, both control words and the master enable are zero, and `ovfPulse` is low.
- R2: Count words can be written and read back at these addresses. Address 0 is count A bits 31:0 and address 1 is count A bits 39:32, held in data bits 7:0. Address 4 is count B bits 31:0 and address 5 is count B bits 39:32. Writing one word leaves the other word of that count unchanged, and the unused high data bits read as zero.
- R3: The reload registers are at addresses 2/3 (A, low/high) and 6/7 (B, low/high). The control words are at 8 (A) and 9 (B), and the master enable is bit 0 of address 10. A control word holds the enable in bit 0, the reload mode in bits 2:1 and the event select in bits 5:4; bit 3 and all bits above 5 read as zero. All of these can be written and read back.
- R4: A counter increments by exactly one on each clock edge at which `evtIn[select]` is high, its enable is set and the master enable is set. Otherwise it holds.
- R5: While the master enable is zero, neither count changes except through register writes, and `ovfPulse` stays low.
- R6: `ovfPulse[i]` is high during the cycle whose closing edge wraps counter i from all ones. With reload mode 0 the count becomes zero.
- R7: With reload mode 1 (self), a wrapping counter loads its own reload value instead of zero.
- R8: With reload mode 2 (partner), a counter loads its reload value on the edge at which the other counter wraps. This holds even when the counter itself is disabled.
- R9: With reload mode 3, a counter reloads on its own wrap or its partner's wrap. When both counters wrap on the same edge, each one takes its own reload value once.
- R10: A register write to a count word takes precedence over an increment or a reload of that counter on the same edge. A counter being written raises no overflow pulse in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 4 | Event pulse lines shared by both counters |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| ovfPulse | output | 2 | Per-counter wrap pulse (bit 0 = A, bit 1 = B) |

## Verification
Read data depends combinationally on the address, and `ovfPulse` is high in the same cycle as the inputs that cause the wrap. A write, an increment or a reload therefore shows up in the readback of the cycle after the edge that performs it. The bench drives new inputs at each falling edge and compares both outputs 1 ns later against a behavioural model. It then updates that model at the rising edge, so every result is compared in the first cycle in which it is due. The read address rotates through all eleven registers during idle and counting stretches, which lets every stored value be observed repeatedly.

// File: rtl/evtPkg.sv
package evtPkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;

  // per-counter register offsets (counter c sits at c*4)
  localparam int OFS_CNT_LO = 0;
  localparam int OFS_CNT_HI = 1;
  localparam int OFS_RLD_LO = 2;
  localparam int OFS_RLD_HI = 3;
  localparam int CTL_BASE   = 8;
  localparam int MASTER_ADR = 10;

  typedef enum logic [1:0] {
    RLD_NONE = 2'd0,
    RLD_SELF = 2'd1,
    RLD_PEER = 2'd2,
    RLD_BOTH = 2'd3
  } rldMode_e;

  typedef struct packed {
    logic [1:0] inc;
    logic [1:0] wrLo;
    logic [1:0] wrHi;
    logic [1:0] loadRld;
  } dpStrobe_t;
endpackage

// File: rtl/evtCtrl.sv
module evtCtrl
  import evtPkg::*;
#(
  parameter int CNT_W   = 40,
  parameter int NUM_EVT = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_EVT-1:0]          evtIn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWrEn,
  input  logic [REG_W-1:0]            regWrData,
  input  logic [1:0][CNT_W-1:0]       cntQ,
  input  logic [1:0]                  cntMax,
  output dpStrobe_t                   strb,
  output logic [1:0][CNT_W-1:0]       rldQ,
  output logic                        masterQ,
  output logic [1:0]                  ovfPulse,
  output logic [REG_W-1:0]            regRdData
);
  localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam int HI_W  = CNT_W - REG_W;

  logic [1:0]            localEn;
  logic [1:0][1:0]       modeQ;
  logic [1:0][SEL_W-1:0] selQ;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      localEn <= '0;
      modeQ   <= '0;
      selQ    <= '0;
      rldQ    <= '0;
      masterQ <= 1'b0;
    end else if (regWrEn) begin
      for (int c = 0; c < 2; c++) begin
        if (regAddr == ADDR_W'(c*4 + OFS_RLD_LO))
          rldQ[c][REG_W-1:0] <= regWrData;
        if (regAddr == ADDR_W'(c*4 + OFS_RLD_HI))
          rldQ[c][CNT_W-1:REG_W] <= regWrData[HI_W-1:0];
        if (regAddr == ADDR_W'(CTL_BASE + c)) begin
          localEn[c] <= regWrData[0];
          modeQ[c]   <= regWrData[2:1];
          selQ[c]    <= regWrData[4 +: SEL_W];
        end
      end
      if (regAddr == ADDR_W'(MASTER_ADR))
        masterQ <= regWrData[0];
    end
  end

  // strobes toward the datapath
  logic [1:0] incV, wrLoV, wrHiV, ovfV, ldV;
  always_comb begin
    for (int c = 0; c < 2; c++) begin
      incV[c]  = masterQ & localEn[c] & evtIn[selQ[c]];
      wrLoV[c] = regWrEn && (regAddr == ADDR_W'(c*4 + OFS_CNT_LO));
      wrHiV[c] = regWrEn && (regAddr == ADDR_W'(c*4 + OFS_CNT_HI));
      ovfV[c]  = incV[c] & cntMax[c] & ~wrLoV[c] & ~wrHiV[c];
    end
    for (int c = 0; c < 2; c++) begin
      ldV[c] = (modeQ[c][0] & ovfV[c]) | (modeQ[c][1] & ovfV[1-c]);
    end
    strb.inc     = incV;
    strb.wrLo    = wrLoV;
    strb.wrHi    = wrHiV;
    strb.loadRld = ldV;
  end

  assign ovfPulse = ovfV;

  // readback mux
  always_comb begin
    regRdData = '0;
    for (int c = 0; c < 2; c++) begin
      if (regAddr == ADDR_W'(c*4 + OFS_CNT_LO)) regRdData = cntQ[c][REG_W-1:0];
      if (regAddr == ADDR_W'(c*4 + OFS_CNT_HI)) regRdData = REG_W'(cntQ[c][CNT_W-1:REG_W]);
      if (regAddr == ADDR_W'(c*4 + OFS_RLD_LO)) regRdData = rldQ[c][REG_W-1:0];
      if (regAddr == ADDR_W'(c*4 + OFS_RLD_HI)) regRdData = REG_W'(rldQ[c][CNT_W-1:REG_W]);
      if (regAddr == ADDR_W'(CTL_BASE + c))
        regRdData = REG_W'({selQ[c], 1'b0, modeQ[c], localEn[c]});
    end
    if (regAddr == ADDR_W'(MASTER_ADR)) regRdData = REG_W'(masterQ);
  end
endmodule

// File: rtl/evtDatapath.sv
module evtDatapath
  import evtPkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [REG_W-1:0]      wrData,
  input  logic [1:0][CNT_W-1:0] rldQ,
  output logic [1:0][CNT_W-1:0] cntQ,
  output logic [1:0]            cntMax
);
  localparam int HI_W = CNT_W - REG_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (strb.wrLo[c])
          cntQ[c][REG_W-1:0] <= wrData;
        else if (strb.wrHi[c])
          cntQ[c][CNT_W-1:REG_W] <= wrData[HI_W-1:0];
        else if (strb.loadRld[c])
          cntQ[c] <= rldQ[c];
        else if (strb.inc[c])
          cntQ[c] <= cntQ[c] + 1'b1;
      end
    end
  end

  generate
    for (genvar c = 0; c < 2; c++) begin : g_max
      assign cntMax[c] = &cntQ[c];
    end
  endgenerate
endmodule

// File: rtl/evtCounterPair.sv
module evtCounterPair
  import evtPkg::*;
#(
  parameter int CNT_W   = 40,
  parameter int NUM_EVT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EVT-1:0]  evtIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic [1:0]          ovfPulse
);
  dpStrobe_t             strb;
  logic [1:0][CNT_W-1:0] cntQ;
  logic [1:0][CNT_W-1:0] rldQ;
  logic [1:0]            cntMax;
  logic                  masterQ;

  evtCtrl #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .cntQ(cntQ), .cntMax(cntMax),
    .strb(strb), .rldQ(rldQ), .masterQ(masterQ), .ovfPulse(ovfPulse),
    .regRdData(regRdData)
  );

  evtDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .rldQ(rldQ), .cntQ(cntQ), .cntMax(cntMax)
  );
endmodule

// File: rtl/evtCounterPairChk.sv
module evtCounterPairChk #(
  parameter int CNT_W  = 40,
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic [ADDR_W-1:0]     regAddr,
  input logic [31:0]           regWrData,
  input logic [1:0]            ovfPulse,
  input logic                  masterQ,
  input logic [1:0][CNT_W-1:0] cntQ,
  input logic [1:0][CNT_W-1:0] rldQ
);
  for (genvar c = 0; c < 2; c++) begin : g_chk
    // R6
    ovf_needs_max_chk: assert property (@(posedge clk) disable iff (!rstN)
      ovfPulse[c] |-> (&cntQ[c]));
    // R7 R8 R9
    wrap_result_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ovfPulse[c] && !regWrEn) |=> (cntQ[c] == '0 || cntQ[c] == rldQ[c]));
    // R4
    step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
      !regWrEn |=> (cntQ[c] == $past(cntQ[c]) || cntQ[c] == $past(cntQ[c]) + 1'b1
                    || cntQ[c] == rldQ[c]));
    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == ADDR_W'(c*4)) |=> (cntQ[c][31:0] == $past(regWrData)));
  end
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!masterQ && !regWrEn) |=> $stable(cntQ));
  // R5
  quiet_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterQ |-> (ovfPulse == 2'b00));
endmodule

bind evtCounterPair evtCounterPairChk #(.CNT_W(CNT_W), .ADDR_W(4)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .ovfPulse(ovfPulse), .masterQ(masterQ),
  .cntQ(cntQ), .rldQ(rldQ)
);

// File: tb/evtCounterPair_bench.sv
module evtCounterPair_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  evtIn = '0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  wire  [31:0] regRdData;
  wire  [1:0]  ovfPulse;

  always #2 clk = ~clk;

  evtCounterPair u_evtCounterPair (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .ovfPulse(ovfPulse)
  );

  // behavioural model
  logic [39:0] mCnt [2];
  logic [39:0] mRld [2];
  logic [5:0]  mCtl [2];
  logic        mMaster;
  int nCmp = 0, nBad = 0, rot = 0;
  bit done = 0;
  string curReq = "R1";

  function automatic logic [31:0] expRead(input logic [3:0] a);
    case (a)
      4'd0: return mCnt[0][31:0];
      4'd1: return {24'd0, mCnt[0][39:32]};
      4'd2: return mRld[0][31:0];
      4'd3: return {24'd0, mRld[0][39:32]};
      4'd4: return mCnt[1][31:0];
      4'd5: return {24'd0, mCnt[1][39:32]};
      4'd6: return mRld[1][31:0];
      4'd7: return {24'd0, mRld[1][39:32]};
      4'd8: return {26'd0, mCtl[0]};
      4'd9: return {26'd0, mCtl[1]};
      4'd10: return {31'd0, mMaster};
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input logic [3:0] ev, input bit we, input logic [3:0] a,
                      input logic [31:0] d);
    bit en[2], wrL[2], wrH[2], ov[2], ld[2];
    logic [1:0] expOvf;
    @(negedge clk);
    evtIn = ev; regWrEn = we; regAddr = a; regWrData = d;
    #1;
    for (int c = 0; c < 2; c++) begin
      en[c]  = mMaster && mCtl[c][0] && ev[mCtl[c][5:4]];
      wrL[c] = we && (a == 4'(c*4));
      wrH[c] = we && (a == 4'(c*4 + 1));
      ov[c]  = en[c] && (mCnt[c] == 40'hFF_FFFF_FFFF) && !wrL[c] && !wrH[c];
    end
    for (int c = 0; c < 2; c++)
      ld[c] = (mCtl[c][1] && ov[c]) || (mCtl[c][2] && ov[1-c]);
    expOvf = {ov[1], ov[0]};
    nCmp++;
    if (ovfPulse !== expOvf) begin
      nBad++;
      $display("FAIL %s ovfPulse actual=%b expected=%b", curReq, ovfPulse, expOvf);
    end
    nCmp++;
    if (regRdData !== expRead(a)) begin
      nBad++;
      $display("FAIL %s read addr %0d actual=%h expected=%h", curReq, a, regRdData, expRead(a));
    end
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      if (wrL[c]) mCnt[c][31:0] = d;
      else if (wrH[c]) mCnt[c][39:32] = d[7:0];
      else if (ld[c]) mCnt[c] = mRld[c];
      else if (en[c]) mCnt[c] = mCnt[c] + 40'd1;
      if (we && a == 4'(c*4 + 2)) mRld[c][31:0] = d;
      if (we && a == 4'(c*4 + 3)) mRld[c][39:32] = d[7:0];
      if (we && a == 4'(8 + c)) mCtl[c] = d[5:0] & 6'b110111;
    end
    if (we && a == 4'd10) mMaster = d[0];
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(4'd0, 1'b1, a, d);
  endtask

  task automatic run(input logic [3:0] ev, input int n);
    for (int i = 0; i < n; i++) begin
      step(ev, 1'b0, 4'(rot % 11), 32'd0);
      rot++;
    end
  endtask

  task automatic setCnt(input int c, input logic [39:0] v);
    wr(4'(c*4), v[31:0]);
    wr(4'(c*4 + 1), {24'd0, v[39:32]});
  endtask

  task automatic setRld(input int c, input logic [39:0] v);
    wr(4'(c*4 + 2), v[31:0]);
    wr(4'(c*4 + 3), {24'd0, v[39:32]});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      mCnt[c] = '0; mRld[c] = '0; mCtl[c] = '0;
    end
    mMaster = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset values of every register and of the pulse outputs
    curReq = "R1";
    for (int a = 0; a < 11; a++) step(4'hF, 1'b0, 4'(a), 32'd0);

    // R2: count words, partial writes, masked high word
    curReq = "R2";
    wr(4'd0, 32'hDEAD_BEEF);
    wr(4'd1, 32'hFFFF_FFA5);
    wr(4'd5, 32'h1234_5678);
    wr(4'd4, 32'h0BAD_F00D);
    run(4'd0, 11);

    // R3: reload words, control word masking, master enable
    curReq = "R3";
    setRld(0, 40'hC3_1111_2222);
    setRld(1, 40'h3C_3333_4444);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd9, 32'h0000_0025);
    wr(4'd10, 32'h0000_0003);
    run(4'd0, 11);
    wr(4'd8, 32'd0);
    wr(4'd9, 32'd0);

    // R4: counting with different selects and event patterns
    curReq = "R4";
    setCnt(0, 40'd0);
    setCnt(1, 40'd100);
    wr(4'd8, 32'h11);
    wr(4'd9, 32'h31);
    for (int i = 0; i < 24; i++) begin
      step(4'((i * 7) ^ (i >> 1)), 1'b0, 4'(i % 2 == 0 ? 0 : 4), 32'd0);
    end
    wr(4'd8, 32'h01);
    run(4'b0101, 8);
    run(4'b1010, 8);

    // R5: master enable stops both counters together
    curReq = "R5";
    wr(4'd10, 32'd0);
    run(4'hF, 11);
    wr(4'd10, 32'd1);
    run(4'hF, 4);

    // R6: plain wrap to zero with pulse
    curReq = "R6";
    wr(4'd9, 32'd0);
    wr(4'd8, 32'h01);
    setCnt(0, 40'hFF_FFFF_FFFD);
    for (int i = 0; i < 5; i++) step(4'h1, 1'b0, 4'd0, 32'd0);
    step(4'h0, 1'b0, 4'd1, 32'd0);

    // R7: self reload
    curReq = "R7";
    setRld(0, 40'h00_0000_0007);
    wr(4'd8, 32'h03);
    setCnt(0, 40'hFF_FFFF_FFFE);
    for (int i = 0; i < 4; i++) step(4'h1, 1'b0, 4'd0, 32'd0);
    step(4'h0, 1'b0, 4'd1, 32'd0);

    // R8: partner reload into a disabled counter
    curReq = "R8";
    wr(4'd8, 32'h01);
    wr(4'd9, 32'h04);
    setRld(1, 40'h02_0000_0100);
    setCnt(1, 40'h00_0000_0055);
    setCnt(0, 40'hFF_FFFF_FFFF);
    step(4'h1, 1'b0, 4'd4, 32'd0);
    step(4'h0, 1'b0, 4'd4, 32'd0);
    step(4'h0, 1'b0, 4'd5, 32'd0);
    step(4'h0, 1'b0, 4'd0, 32'd0);

    // R9: both modes, simultaneous and single wraps
    curReq = "R9";
    setRld(0, 40'h00_0000_0011);
    setRld(1, 40'h00_0000_0022);
    wr(4'd8, 32'h07);
    wr(4'd9, 32'h07);
    setCnt(0, 40'hFF_FFFF_FFFE);
    setCnt(1, 40'hFF_FFFF_FFFE);
    for (int i = 0; i < 3; i++) step(4'h1, 1'b0, 4'(i % 2 == 0 ? 0 : 4), 32'd0);
    run(4'h0, 2);
    setCnt(1, 40'hFF_FFFF_FFFF);
    setCnt(0, 40'h00_0000_0500);
    step(4'h1, 1'b0, 4'd0, 32'd0);
    step(4'h0, 1'b0, 4'd0, 32'd0);
    step(4'h0, 1'b0, 4'd4, 32'd0);

    // R10: register write wins over increment and wrap
    curReq = "R10";
    wr(4'd9, 32'd0);
    wr(4'd8, 32'h03);
    setCnt(0, 40'h00_0000_0010);
    step(4'h1, 1'b1, 4'd0, 32'h0000_0040);
    step(4'h1, 1'b0, 4'd0, 32'd0);
    setCnt(0, 40'hFF_FFFF_FFFF);
    step(4'h1, 1'b1, 4'd0, 32'h0000_0005);
    step(4'h0, 1'b0, 4'd0, 32'd0);
    setCnt(0, 40'hFF_FFFF_FFFF);
    step(4'h1, 1'b1, 4'd1, 32'h0000_0012);
    step(4'h0, 1'b0, 4'd1, 32'd0);
    step(4'h0, 1'b0, 4'd0, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule